// File: doc/BRIEF.md
# Circular Capture Buffer Controller

This block drives a capture engine that stores a stream of sampled words into a memory window used as a ring. Software programs an inclusive lower bound and an exclusive upper bound for the window, and a tail length in bytes. It then writes a control word that starts a run. Each accepted sample is packed and presented on a valid/ready memory write port at the next write address. The address climbs by four per accepted write and returns to the lower bound after the last word below the upper bound.

A run ends in one of three ways. In blind mode it ends once the whole window has been written one time. In triggered mode it ends when the tail length has been written after a one-cycle trigger pulse. A control write with the go bit clear aborts the run. When the run ends, software reads the next write address and the wrap flag. From these two values it can rebuild the oldest-first order of the stored data.

Top module: `cap_ring_ctrl`

## Requirements
- R1: Register indices are 2 = window low, 3 = window high (exclusive), 4 = tail length in bytes, 0 = control, 1 = status and 5 = next write address. For the three address and length registers, bits 1:0 of a write are dropped and read back as zero.
- R2: A control write with bit 0 set starts a run. It clears all status bits and sets the next write address to the window low bound. The status register carries done in bit 0, overflow in bit 1 and wrapped in bit 2.
- R3: A sample that arrives while the previous word is still waiting on the memory port (ready low) is dropped. The overflow bit is set and the run continues.
- R4: Writes go to ascending word addresses starting at the window low bound. The write after the last word below the window high bound goes to the low bound, and this sets the wrapped bit.
- R5: With control bit 4 set (blind mode), the run ends with done after exactly (high - low)/4 writes. No further write follows, and a trigger pulse has no effect.
- R6: With control bit 4 clear, the run ends with done after exactly tail/4 writes accepted in cycles after the first trigger pulse.
- R7: Packing is taken from the control word that starts the run. Bit 8 clear stores the full 32-bit sample. Bit 8 set with bit 9 clear stores sample[15:0] zero-extended. Bits 8 and 9 both set store sample[31:16] zero-extended.
- R8: A control write with bit 0 clear aborts the run without setting done. No write follows it, and the next write address is kept.
- R9: Samples presented while no run is active are ignored and produce no write.
- R10: While the memory port shows valid and ready is low, valid, address and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| sample_valid | input | 1 | Sample present this cycle |
| sample_data | input | 32 | Sample word |
| trig | input | 1 | One-cycle trigger pulse |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Write address; equals the next write address |
| mem_data | output | 32 | Packed write data |

## Verification
A register write takes effect at the clock edge on which the strobe is seen. Status and address reads are combinational, so they reflect that edge from the next falling edge onward. A sample seen at edge N appears on the memory port after edge N. With ready high it is written at edge N+1, and the address and status change after N+1. The bench drives all inputs on falling edges and records every accepted write at the rising edge. It then waits at least two idle cycles after the last stimulus before it compares write counts, addresses, data and status against values derived from the window bounds and sample sequence of each test.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int IDX_W  = 3;

    // control word bit positions
    localparam int CB_GO    = 0;
    localparam int CB_BLIND = 4;
    localparam int CB_HALF  = 8;
    localparam int CB_UPPER = 9;

    typedef enum logic [IDX_W-1:0] {
        RG_CTRL   = 3'd0,
        RG_STAT   = 3'd1,
        RG_WIN_LO = 3'd2,
        RG_WIN_HI = 3'd3,
        RG_TAIL   = 3'd4,
        RG_NEXT   = 3'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        PK_FULL = 2'd0,
        PK_LOW  = 2'd1,
        PK_HIGH = 2'd2
    } pack_e;

    typedef struct packed {
        logic  blind;
        pack_e pack;
    } cap_mode_t;

    typedef struct packed {
        logic wrapped;
        logic ovf;
        logic done;
    } cap_stat_t;

    function automatic cap_mode_t decode_ctrl(input logic [WORD_W-1:0] w);
        cap_mode_t m;
        m.blind = w[CB_BLIND];
        if (!w[CB_HALF])
            m.pack = PK_FULL;
        else if (w[CB_UPPER])
            m.pack = PK_HIGH;
        else
            m.pack = PK_LOW;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input pack_e p, input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        case (p)
            PK_LOW:  r = {{HALF_W{1'b0}}, d[HALF_W-1:0]};
            PK_HIGH: r = {{HALF_W{1'b0}}, d[WORD_W-1:HALF_W]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cap_ring_regs.sv
module cap_ring_regs
    import cap_ring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  cap_stat_t         stat,
    input  logic [AW-1:0]     next_addr,
    output logic [AW-1:0]     win_lo,
    output logic [AW-1:0]     win_hi,
    output logic [AW-1:0]     tail_len,
    output cap_mode_t         mode,
    output logic              go,
    output logic              halt,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [WORD_W-1:0] CTRL_MASK =
        (WORD_W'(1) << CB_GO) | (WORD_W'(1) << CB_BLIND) |
        (WORD_W'(1) << CB_HALF) | (WORD_W'(1) << CB_UPPER);

    reg_idx_e          sel;
    logic [WORD_W-1:0] ctrl_q;

    assign sel  = reg_idx_e'(idx);
    assign go   = wr && (sel == RG_CTRL) && wdata[CB_GO];
    assign halt = wr && (sel == RG_CTRL) && !wdata[CB_GO];

    always_ff @(posedge clk) begin
        if (rst) begin
            win_lo   <= '0;
            win_hi   <= '0;
            tail_len <= '0;
            ctrl_q   <= '0;
            mode     <= '0;
        end else if (wr) begin
            case (sel)
                RG_WIN_LO: win_lo   <= {wdata[AW-1:2], 2'b00};
                RG_WIN_HI: win_hi   <= {wdata[AW-1:2], 2'b00};
                RG_TAIL:   tail_len <= {wdata[AW-1:2], 2'b00};
                RG_CTRL: begin
                    ctrl_q <= wdata & CTRL_MASK;
                    if (wdata[CB_GO])
                        mode <= decode_ctrl(wdata);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            RG_CTRL:   rdata = ctrl_q;
            RG_STAT:   rdata = WORD_W'(stat);
            RG_WIN_LO: rdata = WORD_W'(win_lo);
            RG_WIN_HI: rdata = WORD_W'(win_hi);
            RG_TAIL:   rdata = WORD_W'(tail_len);
            RG_NEXT:   rdata = WORD_W'(next_addr);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/cap_ring_stage.sv
module cap_ring_stage
    import cap_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic              go,
    input  logic              halt,
    input  logic              finish,
    input  pack_e             pack,
    input  logic              sample_valid,
    input  logic [WORD_W-1:0] sample_data,
    input  logic              mem_ready,
    output logic              pend,
    output logic [WORD_W-1:0] pend_data,
    output logic              ovf_flag
);

    logic load;
    logic clash;

    assign load  = running && sample_valid && !finish && (!pend || mem_ready);
    assign clash = running && sample_valid && pend && !mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_data <= '0;
            ovf_flag  <= 1'b0;
        end else if (go) begin
            pend     <= 1'b0;
            ovf_flag <= 1'b0;
        end else if (halt || finish) begin
            pend <= 1'b0;
        end else begin
            if (load) begin
                pend      <= 1'b1;
                pend_data <= pack_word(pack, sample_data);
            end else if (pend && mem_ready) begin
                pend <= 1'b0;
            end
            if (clash)
                ovf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/cap_ring_addr.sv
module cap_ring_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          halt,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    input  logic [AW-1:0] tail_len,
    input  logic          blind,
    input  logic          trig,
    input  logic          accept,
    output logic [AW-1:0] cur,
    output logic          run,
    output logic          finish,
    output logic          done_flag,
    output logic          wrap_flag
);

    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] step_addr;
    logic [AW-1:0] span;
    logic [AW-1:0] filled;
    logic [AW-1:0] left;
    logic          trig_seen;
    logic          at_end;

    assign step_addr = cur + STEP;
    assign span      = win_hi - win_lo;
    assign at_end    = (step_addr == win_hi);

    always_comb begin
        finish = 1'b0;
        if (run && accept) begin
            if (blind)
                finish = (filled + STEP == span);
            else
                finish = trig_seen && (left == STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            run       <= 1'b0;
            filled    <= '0;
            left      <= '0;
            trig_seen <= 1'b0;
            done_flag <= 1'b0;
            wrap_flag <= 1'b0;
        end else if (go) begin
            cur       <= win_lo;
            run       <= 1'b1;
            filled    <= '0;
            left      <= '0;
            trig_seen <= 1'b0;
            done_flag <= 1'b0;
            wrap_flag <= 1'b0;
        end else if (halt) begin
            run <= 1'b0;
        end else begin
            if (accept) begin
                cur    <= at_end ? win_lo : step_addr;
                filled <= filled + STEP;
                if (at_end)
                    wrap_flag <= 1'b1;
            end
            if (run && !blind && trig && !trig_seen) begin
                trig_seen <= 1'b1;
                left      <= tail_len;
            end else if (accept && trig_seen) begin
                left <= left - STEP;
            end
            if (finish) begin
                run       <= 1'b0;
                done_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cap_ring_ctrl.sv
module cap_ring_ctrl
    import cap_ring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_idx,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          sample_valid,
    input  logic [31:0]   sample_data,
    input  logic          trig,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_data
);

    logic [AW-1:0] win_lo;
    logic [AW-1:0] win_hi;
    logic [AW-1:0] tail_len;
    cap_mode_t     mode;
    cap_stat_t     stat;
    logic          go;
    logic          halt;
    logic          ctrl_wr;
    logic          run;
    logic          finish;
    logic          done_flag;
    logic          wrap_flag;
    logic          ovf_flag;
    logic          accept;
    logic [AW-1:0] cur;

    assign accept  = mem_valid && mem_ready;
    assign ctrl_wr = go || halt;
    assign stat    = '{wrapped: wrap_flag, ovf: ovf_flag, done: done_flag};
    assign mem_addr = cur;

    cap_ring_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .stat      (stat),
        .next_addr (cur),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .tail_len  (tail_len),
        .mode      (mode),
        .go        (go),
        .halt      (halt),
        .rdata     (reg_rdata)
    );

    cap_ring_stage u_stage (
        .clk          (clk),
        .rst          (rst),
        .running      (run),
        .go           (go),
        .halt         (halt),
        .finish       (finish),
        .pack         (mode.pack),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .mem_ready    (mem_ready),
        .pend         (mem_valid),
        .pend_data    (mem_data),
        .ovf_flag     (ovf_flag)
    );

    cap_ring_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .halt      (halt),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .tail_len  (tail_len),
        .blind     (mode.blind),
        .trig      (trig),
        .accept    (accept),
        .cur       (cur),
        .run       (run),
        .finish    (finish),
        .done_flag (done_flag),
        .wrap_flag (wrap_flag)
    );

endmodule

// File: rtl/cap_ring_ctrl_chk.sv
module cap_ring_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_data,
    input logic [AW-1:0] win_lo,
    input logic [AW-1:0] win_hi,
    input logic          run,
    input logic          ctrl_wr,
    input logic          sample_valid,
    input logic          ovf_flag,
    input logic          done_flag,
    input logic          wrap_flag
);

    // R4: every request targets an aligned word inside the window
    p_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00) && (mem_addr >= win_lo) && (mem_addr < win_hi));

    // R4: the write at the last word returns the address to the low bound
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !ctrl_wr && (mem_addr + AW'(4) == win_hi))
        |=> (mem_addr == win_lo) && wrap_flag);

    // R10: a stalled request holds
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready && !ctrl_wr)
        |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R3: a sample against a stalled request raises overflow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (run && sample_valid && mem_valid && !mem_ready && !ctrl_wr) |=> ovf_flag);

    // R5: completion leaves the port quiet and the run stopped
    p_done_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> !mem_valid && !run);

    // R9: no request without an active run
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mem_valid);

endmodule

bind cap_ring_ctrl cap_ring_ctrl_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .win_lo       (win_lo),
    .win_hi       (win_hi),
    .run          (run),
    .ctrl_wr      (ctrl_wr),
    .sample_valid (sample_valid),
    .ovf_flag     (ovf_flag),
    .done_flag    (done_flag),
    .wrap_flag    (wrap_flag)
);

// File: tb/cap_ring_ctrl_tb.sv
`timescale 1ns/1ps
module cap_ring_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        sample_valid = 1'b0;
    logic [31:0] sample_data = 32'd0;
    logic        trig = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int          wcount = 0;
    logic [31:0] waddr [0:63];
    logic [31:0] wdat  [0:63];

    always #2.5 clk = ~clk;

    cap_ring_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .trig         (trig),
        .mem_valid    (mem_valid),
        .mem_ready    (mem_ready),
        .mem_addr     (mem_addr),
        .mem_data     (mem_data)
    );

    // memory-side monitor
    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (wcount < 64) begin
                waddr[wcount] <= mem_addr;
                wdat[wcount]  <= mem_data;
            end
            wcount <= wcount + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] i, output logic [31:0] d);
        @(negedge clk);
        reg_idx = i;
        #1 d = reg_rdata;
    endtask

    task automatic send_sample(input logic [31:0] d);
        @(negedge clk);
        sample_valid = 1'b1; sample_data = d;
        @(negedge clk);
        sample_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_window(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] tl);
        reg_write(3'd2, lo);
        reg_write(3'd3, hi);
        reg_write(3'd4, tl);
    endtask

    task automatic t_reset_and_regs();
        logic [31:0] v;
        reg_read(3'd1, v);    check("R2 status after reset", v, 32'h0);
        reg_read(3'd5, v);    check("R1 next addr after reset", v, 32'h0);
        check("R9 no request after reset", {31'd0, mem_valid}, 32'h0);
        reg_write(3'd2, 32'h0000_1003);
        reg_read(3'd2, v);    check("R1 window low drops bits 1:0", v, 32'h0000_1000);
        reg_write(3'd3, 32'h0000_1022);
        reg_read(3'd3, v);    check("R1 window high drops bits 1:0", v, 32'h0000_1020);
        reg_write(3'd4, 32'h0000_000B);
        reg_read(3'd4, v);    check("R1 tail length drops bits 1:0", v, 32'h0000_0008);
        send_sample(32'hDEAD0001);
        idle(2);
        check("R9 idle sample ignored", 32'(wcount), 32'd0);
    endtask

    task automatic t_blind();
        logic [31:0] v;
        int base;
        base = wcount;
        set_window(32'h100, 32'h110, 32'h4);
        reg_write(3'd0, 32'h11);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sample_valid = 1'b1; sample_data = 32'hA0 + 32'(i);
            trig = (i == 1);
        end
        @(negedge clk);
        sample_valid = 1'b0; trig = 1'b0;
        idle(3);
        check("R5 blind write count (trigger ignored)", 32'(wcount - base), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R4 blind ascending addr", waddr[base + i], 32'h100 + 32'(4 * i));
            check("R7 full word data", wdat[base + i], 32'hA0 + 32'(i));
        end
        reg_read(3'd1, v);    check("R5 status done and wrapped", v, 32'h5);
        reg_read(3'd5, v);    check("R4 next addr back at low", v, 32'h100);
        send_sample(32'h55);
        idle(2);
        check("R5 no write after done", 32'(wcount - base), 32'd4);
    endtask

    task automatic t_triggered();
        logic [31:0] v;
        int base;
        base = wcount;
        set_window(32'h200, 32'h210, 32'h8);
        reg_write(3'd0, 32'h01);
        for (int i = 0; i < 6; i++) send_sample(32'hB0 + 32'(i));
        idle(1);
        check("R4 ring writes before trigger", 32'(wcount - base), 32'd6);
        check("R4 wrapped write at low", waddr[base + 4], 32'h200);
        reg_read(3'd1, v);    check("R4 wrapped bit, not done", v, 32'h4);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        for (int i = 6; i < 10; i++) send_sample(32'hB0 + 32'(i));
        idle(2);
        check("R6 tail write count", 32'(wcount - base), 32'd8);
        check("R6 tail first addr", waddr[base + 6], 32'h208);
        check("R6 tail last data", wdat[base + 7], 32'hB7);
        reg_read(3'd1, v);    check("R6 status done and wrapped", v, 32'h5);
        reg_read(3'd5, v);    check("R6 next addr", v, 32'h200);
    endtask

    task automatic t_pack_abort();
        logic [31:0] v;
        int base;
        base = wcount;
        set_window(32'h300, 32'h340, 32'h4);
        reg_write(3'd0, 32'h111);
        send_sample(32'hABCD1234);
        idle(1);
        check("R7 low half packing", wdat[base], 32'h0000_1234);
        reg_write(3'd0, 32'h311);
        send_sample(32'hABCD1234);
        idle(1);
        check("R7 upper half packing", wdat[base + 1], 32'h0000_ABCD);
        check("R2 restart writes at low", waddr[base + 1], 32'h300);
        reg_write(3'd0, 32'h0);
        send_sample(32'h77777777);
        idle(2);
        check("R8 no write after abort", 32'(wcount - base), 32'd2);
        reg_read(3'd1, v);    check("R8 abort leaves done clear", v, 32'h0);
        reg_read(3'd5, v);    check("R8 next addr kept", v, 32'h304);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        int base;
        base = wcount;
        set_window(32'h400, 32'h420, 32'h4);
        @(negedge clk); mem_ready = 1'b0;
        reg_write(3'd0, 32'h11);
        @(negedge clk); sample_valid = 1'b1; sample_data = 32'h11111111;
        @(negedge clk); sample_data = 32'h22222222;
        @(negedge clk); sample_valid = 1'b0;
        idle(3);
        check("R10 valid held while stalled", {31'd0, mem_valid}, 32'h1);
        check("R10 addr held while stalled", mem_addr, 32'h400);
        check("R10 data held while stalled", mem_data, 32'h11111111);
        reg_read(3'd1, v);    check("R3 overflow bit", v, 32'h2);
        mem_ready = 1'b1;
        idle(2);
        check("R3 only first sample written", 32'(wcount - base), 32'd1);
        check("R3 first sample data", wdat[base], 32'h11111111);
        send_sample(32'h33333333);
        idle(1);
        check("R3 capture continues after drop", waddr[base + 1], 32'h404);
        reg_write(3'd0, 32'h11);
        reg_read(3'd1, v);    check("R2 start clears status", v, 32'h0);
        reg_read(3'd5, v);    check("R2 start resets next addr", v, 32'h400);
        reg_write(3'd0, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_and_regs();
        t_blind();
        t_triggered();
        t_pack_abort();
        t_overflow();
        idle(2);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule